// File: doc/BRIEF.md
# Serial Clock and Chip-Select Timing Generator

This block generates the serial clock and the chip-select timing for a quad-SPI master. It runs on the peripheral clock. It reads two configuration words: a clock word and a mode word. From these it takes the clock idle level, the sampling phase, a baud divider and three programmable delays:

- the delay from chip-select assertion to the first clock edge;
- the gap between consecutive transfers while chip-select stays low;
- the minimum time chip-select stays high after it is released.

All three delays are counted in peripheral clocks. A delay field of zero still gives one clock.

The frame sequencer starts a transfer with a `start` pulse. The block then drives `2*NBITS` serial clock edges. On each edge it sends the serializer either a shift strobe or a sample strobe. It reports the end of each transfer with `xfer_done`. A two-bit chip-select mode in the mode word decides what happens after a transfer:

- chip-select is kept low;
- chip-select is released after a `last_xfer` command;
- chip-select is released after every transfer.

Once the inactive time has elapsed, `rel_done` reports the release to the sequencer. `ready` shows when a new `start` is accepted.

The controller steps through six states:

| State | Chip-select | Activity |
|---|---|---|
| IDLE | high | waits for `start` |
| SETUP | low | counts the setup delay |
| SHIFT | low | runs the serial clock edges |
| GAP | low | counts the between-transfer gap |
| HOLD | low | waits for `start` or a release |
| RELEASE | high | counts the inactive delay |

The transitions are:

- IDLE to SETUP on `start`.
- SETUP to SHIFT when the setup count expires.
- SHIFT to RELEASE on the final edge if chip-select must be released.
- SHIFT to GAP on the final edge otherwise.
- GAP to HOLD when the gap count expires.
- HOLD to RELEASE on a release request in mode 1.
- HOLD to SHIFT on `start`.
- RELEASE to IDLE when the inactive count expires.

Top module: `qspi_sck_gen`

## Requirements
- R1: While reset is asserted and right after it, `cs_n` is 1, `ready` is 1, `sck` equals the polarity bit, and `shift_stb`, `sample_stb`, `xfer_done` and `rel_done` are 0.
- R2: Outside a transfer, `sck` rests at the level of clock-word bit 0 (1 means idle high), and it is back at that level on the final edge of every transfer.
- R3: During a transfer, `sck` toggles once every div+1 peripheral clocks, where div is clock-word bits 15:8. A serial period is therefore 2*(div+1) clocks. A transfer makes exactly 2*NBITS toggles.
- R4: After `start` in IDLE, `cs_n` falls in the next cycle. It stays low for max(s,1) clocks before the serial clock phase begins, where s is clock-word bits 23:16. The first toggle follows after a further div+1 clocks. `sck` never toggles while `cs_n` is high.
- R5: Every toggle carries exactly one strobe. With clock-word bit 1 at 0, leading edges (the 1st, 3rd, ... toggles) give `sample_stb` and trailing edges give `shift_stb`. With bit 1 at 1, the roles swap.
- R6: `xfer_done` pulses for one cycle, coincident with the final toggle of a transfer.
- R7: A transfer that keeps chip-select is followed by a gap of max(g,1) clocks, where g is mode-word bits 23:16. `ready` then rises with `cs_n` low. A `start` in that state begins the serial clock phase directly, without a setup delay.
- R8: With chip-select mode (mode-word bits 5:4) equal to 2 or 3, `cs_n` rises on the final toggle of every transfer.
- R9: In chip-select mode 1, a `last_xfer` pulse makes chip-select release. During a transfer, the release happens on that transfer's final toggle. While waiting between transfers, `cs_n` rises in the cycle after the pulse. A release request in that waiting state wins over a simultaneous `start`.
- R10: In chip-select mode 0, `last_xfer` has no effect: `cs_n` stays low across transfers until reset.
- R11: After `cs_n` rises, it stays high for max(r,1) clocks, where r is mode-word bits 31:24. Then `rel_done` pulses for one cycle with `ready` high.
- R12: `start` is ignored whenever `ready` is low. This covers the setup delay, the transfer, the gap and the inactive delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_cfg | input | CFG_W | Clock word: polarity, phase, divider, setup delay |
| mode_cfg | input | CFG_W | Mode word: chip-select mode, gap delay, inactive delay |
| start | input | 1 | Begin a transfer (taken only while `ready`) |
| last_xfer | input | 1 | Last-transfer command pulse |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip-select, active low |
| shift_stb | output | 1 | Serializer shift strobe |
| sample_stb | output | 1 | Serializer sample strobe |
| xfer_done | output | 1 | One-cycle pulse at the end of a transfer |
| rel_done | output | 1 | One-cycle pulse when the chip-select release completes |
| ready | output | 1 | A `start` would be accepted this cycle |

## Verification
The bench builds the block with NBITS set to 4. Each transfer is then only eight edges long, so one run can visit every chip-select mode many times. That run also covers:

- divider values 0 to 2;
- delay fields of zero next to non-zero ones;
- both polarities and both phases.

The shorter frames also bring the corner timings within reach: a release request that arrives while the block waits in HOLD, and a `start` that arrives during the setup or inactive delays. Every output is compared against a behavioural reference on every clock.

// File: rtl/qsck_pkg.sv
package qsck_pkg;

    localparam int FLD_W     = 8;
    localparam int POL_BIT   = 0;
    localparam int PHA_BIT   = 1;
    localparam int DIV_LSB   = 8;
    localparam int SETUP_LSB = 16;
    localparam int CSM_LSB   = 4;
    localparam int GAP_LSB   = 16;
    localparam int INACT_LSB = 24;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETUP   = 3'd1,
        ST_SHIFT   = 3'd2,
        ST_GAP     = 3'd3,
        ST_HOLD    = 3'd4,
        ST_RELEASE = 3'd5
    } qsck_state_e;

    typedef enum logic [1:0] {
        CSM_KEEP    = 2'd0,
        CSM_ON_LAST = 2'd1,
        CSM_EACH    = 2'd2,
        CSM_EACH_B  = 2'd3
    } qsck_csmode_e;

endpackage

// File: rtl/qsck_cfg_decode.sv
module qsck_cfg_decode
    import qsck_pkg::*;
#(
    parameter int CFG_W = 32,
    parameter int CNT_W = FLD_W
) (
    input  logic [CFG_W-1:0] clk_cfg,
    input  logic [CFG_W-1:0] mode_cfg,
    output logic             cpol,
    output logic             cpha,
    output logic [CNT_W-1:0] div_ld,
    output logic [CNT_W-1:0] setup_ld,
    output logic [CNT_W-1:0] gap_ld,
    output logic [CNT_W-1:0] inact_ld,
    output qsck_csmode_e     csm
);

    logic [FLD_W-1:0] setup_raw;
    logic [FLD_W-1:0] gap_raw;
    logic [FLD_W-1:0] inact_raw;
    logic             unused_cfg_bits;

    // A zero delay field still costs one clock: the counters are
    // preloaded with max(field,1)-1 and run down to zero.
    function automatic logic [CNT_W-1:0] min_one_load(input logic [FLD_W-1:0] v);
        return (v == '0) ? '0 : CNT_W'(v - 1'b1);
    endfunction

    always_comb begin
        cpol      = clk_cfg[POL_BIT];
        cpha      = clk_cfg[PHA_BIT];
        div_ld    = CNT_W'(clk_cfg[DIV_LSB +: FLD_W]);
        setup_raw = clk_cfg[SETUP_LSB +: FLD_W];
        gap_raw   = mode_cfg[GAP_LSB +: FLD_W];
        inact_raw = mode_cfg[INACT_LSB +: FLD_W];
        setup_ld  = min_one_load(setup_raw);
        gap_ld    = min_one_load(gap_raw);
        inact_ld  = min_one_load(inact_raw);
        csm       = qsck_csmode_e'(mode_cfg[CSM_LSB +: 2]);
    end

    assign unused_cfg_bits = ^{clk_cfg, mode_cfg};

endmodule

// File: rtl/qsck_edge_gen.sv
module qsck_edge_gen #(
    parameter int NBITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_shift,
    input  logic tick,
    input  logic cpol,
    input  logic cpha,
    output logic sck,
    output logic shift_stb,
    output logic sample_stb,
    output logic last_edge
);

    localparam int EDGES = 2 * NBITS;
    localparam int EW    = (EDGES > 2) ? $clog2(EDGES) : 1;

    logic          phase_q;
    logic [EW-1:0] edge_cnt;
    logic          is_sample;

    // Even edge index = leading edge. Phase 0 samples on leading edges.
    assign is_sample = (edge_cnt[0] == cpha);
    assign last_edge = (edge_cnt == EW'(EDGES - 1));
    assign sck       = cpol ^ phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q    <= 1'b0;
            edge_cnt   <= '0;
            shift_stb  <= 1'b0;
            sample_stb <= 1'b0;
        end else begin
            shift_stb  <= tick & ~is_sample;
            sample_stb <= tick & is_sample;
            if (!in_shift) begin
                phase_q  <= 1'b0;
                edge_cnt <= '0;
            end else if (tick) begin
                phase_q  <= ~phase_q;
                edge_cnt <= edge_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/qsck_fsm.sv
module qsck_fsm
    import qsck_pkg::*;
#(
    parameter int CNT_W = FLD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             last_xfer,
    input  logic             last_edge,
    input  logic [CNT_W-1:0] div_ld,
    input  logic [CNT_W-1:0] setup_ld,
    input  logic [CNT_W-1:0] gap_ld,
    input  logic [CNT_W-1:0] inact_ld,
    input  qsck_csmode_e     csm,
    output logic             tick,
    output logic             in_shift,
    output logic             cs_n,
    output logic             ready,
    output logic             xfer_done,
    output logic             rel_done
);

    qsck_state_e      state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             last_pend, last_pend_n;
    logic             cnt_zero;
    logic             cs_active;
    logic             release_req;
    logic             release_after;

    assign cnt_zero      = (cnt == '0);
    assign cs_active     = (state == ST_SETUP) || (state == ST_SHIFT) ||
                           (state == ST_GAP)   || (state == ST_HOLD);
    assign release_req   = last_pend || (last_xfer && (csm == CSM_ON_LAST));
    assign release_after = (csm == CSM_EACH) || (csm == CSM_EACH_B) || release_req;
    assign last_pend_n   = cs_active ? release_req : 1'b0;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            last_pend <= 1'b0;
        end else begin
            state     <= state_n;
            cnt       <= cnt_n;
            last_pend <= last_pend_n;
        end
    end

    // Next state and delay counter
    always_comb begin
        state_n = state;
        cnt_n   = cnt_zero ? cnt : cnt - 1'b1;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_n = ST_SETUP;
                    cnt_n   = setup_ld;
                end
            end
            ST_SETUP: begin
                if (cnt_zero) begin
                    state_n = ST_SHIFT;
                    cnt_n   = div_ld;
                end
            end
            ST_SHIFT: begin
                if (cnt_zero) begin
                    cnt_n = div_ld;
                    if (last_edge) begin
                        if (release_after) begin
                            state_n = ST_RELEASE;
                            cnt_n   = inact_ld;
                        end else begin
                            state_n = ST_GAP;
                            cnt_n   = gap_ld;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (cnt_zero) state_n = ST_HOLD;
            end
            ST_HOLD: begin
                if ((csm == CSM_ON_LAST) && release_req) begin
                    state_n = ST_RELEASE;
                    cnt_n   = inact_ld;
                end else if (start) begin
                    state_n = ST_SHIFT;
                    cnt_n   = div_ld;
                end
            end
            ST_RELEASE: begin
                if (cnt_zero) state_n = ST_IDLE;
            end
            default: begin
                state_n = ST_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        in_shift = (state == ST_SHIFT);
        tick     = in_shift && cnt_zero;
        cs_n     = !cs_active;
        ready    = (state == ST_IDLE) || (state == ST_HOLD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xfer_done <= 1'b0;
            rel_done  <= 1'b0;
        end else begin
            xfer_done <= tick && last_edge;
            rel_done  <= (state == ST_RELEASE) && cnt_zero;
        end
    end

endmodule

// File: rtl/qspi_sck_gen.sv
module qspi_sck_gen
    import qsck_pkg::*;
#(
    parameter int NBITS = 8,
    parameter int CFG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] clk_cfg,
    input  logic [CFG_W-1:0] mode_cfg,
    input  logic             start,
    input  logic             last_xfer,
    output logic             sck,
    output logic             cs_n,
    output logic             shift_stb,
    output logic             sample_stb,
    output logic             xfer_done,
    output logic             rel_done,
    output logic             ready
);

    localparam int CNT_W = FLD_W;

    logic             cpol, cpha;
    logic [CNT_W-1:0] div_ld, setup_ld, gap_ld, inact_ld;
    qsck_csmode_e     csm;
    logic             tick, in_shift, last_edge;

    qsck_cfg_decode #(.CFG_W(CFG_W), .CNT_W(CNT_W)) u_decode (
        .clk_cfg  (clk_cfg),
        .mode_cfg (mode_cfg),
        .cpol     (cpol),
        .cpha     (cpha),
        .div_ld   (div_ld),
        .setup_ld (setup_ld),
        .gap_ld   (gap_ld),
        .inact_ld (inact_ld),
        .csm      (csm)
    );

    qsck_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .last_xfer (last_xfer),
        .last_edge (last_edge),
        .div_ld    (div_ld),
        .setup_ld  (setup_ld),
        .gap_ld    (gap_ld),
        .inact_ld  (inact_ld),
        .csm       (csm),
        .tick      (tick),
        .in_shift  (in_shift),
        .cs_n      (cs_n),
        .ready     (ready),
        .xfer_done (xfer_done),
        .rel_done  (rel_done)
    );

    qsck_edge_gen #(.NBITS(NBITS)) u_edges (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_shift   (in_shift),
        .tick       (tick),
        .cpol       (cpol),
        .cpha       (cpha),
        .sck        (sck),
        .shift_stb  (shift_stb),
        .sample_stb (sample_stb),
        .last_edge  (last_edge)
    );

endmodule

// File: rtl/qsck_checker.sv
module qsck_checker #(
    parameter int CFG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CFG_W-1:0] clk_cfg,
    input logic [CFG_W-1:0] mode_cfg,
    input logic             sck,
    input logic             cs_n,
    input logic             shift_stb,
    input logic             sample_stb,
    input logic             xfer_done,
    input logic             rel_done,
    input logic             ready
);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({shift_stb, sample_stb})); // R5

    AST_STROBE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_stb || sample_stb) |-> !$stable(sck)); // R3

    AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (sck == clk_cfg[0])); // R2

    AST_EACH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && mode_cfg[5]) |-> cs_n); // R8

    AST_MODE0_KEEPS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_cfg[5:4] == 2'd0) && $past(!cs_n)) |-> !cs_n); // R10

    AST_RELEASE_DONE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        rel_done |-> (cs_n && ready)); // R11

    AST_TOGGLE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sck) && $stable(clk_cfg[0])) |-> $past(!cs_n)); // R4

endmodule

bind qspi_sck_gen qsck_checker #(.CFG_W(CFG_W)) u_qsck_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_cfg    (clk_cfg),
    .mode_cfg   (mode_cfg),
    .sck        (sck),
    .cs_n       (cs_n),
    .shift_stb  (shift_stb),
    .sample_stb (sample_stb),
    .xfer_done  (xfer_done),
    .rel_done   (rel_done),
    .ready      (ready)
);

// File: tb/qspi_sck_gen_bench.sv
module qspi_sck_gen_bench;

    localparam int NB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] clk_cfg = '0;
    logic [31:0] mode_cfg = '0;
    logic        start = 1'b0;
    logic        last_xfer = 1'b0;
    logic        sck, cs_n, shift_stb, sample_stb, xfer_done, rel_done, ready;

    int  checks = 0;
    int  failures = 0;
    bit  finished = 0;

    always #5 clk = ~clk;

    qspi_sck_gen #(.NBITS(NB), .CFG_W(32)) u_qspi_sck_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_cfg    (clk_cfg),
        .mode_cfg   (mode_cfg),
        .start      (start),
        .last_xfer  (last_xfer),
        .sck        (sck),
        .cs_n       (cs_n),
        .shift_stb  (shift_stb),
        .sample_stb (sample_stb),
        .xfer_done  (xfer_done),
        .rel_done   (rel_done),
        .ready      (ready)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1 setup, 2 clocking, 3 gap,
    // 4 waiting with chip-select low, 5 inactive time.
    int m_ph = 0, m_left = 0, m_edges = 0;
    bit m_tog = 0, m_last = 0;
    bit e_shift = 0, e_sample = 0, e_done = 0, e_rel = 0;
    bit m_req;
    int m_csm;

    function automatic int at_least_one(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    always @(posedge clk) begin
        e_shift = 0; e_sample = 0; e_done = 0; e_rel = 0;
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_edges = 0; m_tog = 0; m_last = 0;
        end else begin
            m_csm = int'(mode_cfg[5:4]);
            m_req = m_last || (last_xfer && m_csm == 1);
            if (m_ph >= 1 && m_ph <= 4) m_last = m_req;
            case (m_ph)
                0: if (start) begin
                    m_ph = 1;
                    m_left = at_least_one(int'(clk_cfg[23:16]));
                end
                1: begin
                    m_left--;
                    if (m_left == 0) begin
                        m_ph = 2; m_left = int'(clk_cfg[15:8]) + 1; m_edges = 0;
                    end
                end
                2: begin
                    m_left--;
                    if (m_left == 0) begin
                        if (((m_edges % 2) == 0) != clk_cfg[1]) e_sample = 1;
                        else e_shift = 1;
                        m_tog = !m_tog;
                        m_edges++;
                        m_left = int'(clk_cfg[15:8]) + 1;
                        if (m_edges == 2 * NB) begin
                            e_done = 1;
                            if (m_csm >= 2 || (m_csm == 1 && m_req)) begin
                                m_ph = 5; m_last = 0;
                                m_left = at_least_one(int'(mode_cfg[31:24]));
                            end else begin
                                m_ph = 3;
                                m_left = at_least_one(int'(mode_cfg[23:16]));
                            end
                        end
                    end
                end
                3: begin
                    m_left--;
                    if (m_left == 0) m_ph = 4;
                end
                4: begin
                    if (m_csm == 1 && m_req) begin
                        m_ph = 5; m_last = 0;
                        m_left = at_least_one(int'(mode_cfg[31:24]));
                    end else if (start) begin
                        m_ph = 2; m_left = int'(clk_cfg[15:8]) + 1; m_edges = 0;
                    end
                end
                default: begin
                    m_left--;
                    if (m_left == 0) begin
                        m_ph = 0; e_rel = 1;
                    end
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(cs_n == !(m_ph >= 1 && m_ph <= 4), "cs_n R4 R8 R9 R10 R11",
                int'(cs_n), int'(!(m_ph >= 1 && m_ph <= 4)));
            chk(sck == (clk_cfg[0] ^ m_tog), "sck R2 R3", int'(sck), int'(clk_cfg[0] ^ m_tog));
            chk(shift_stb == e_shift, "shift_stb R5", int'(shift_stb), int'(e_shift));
            chk(sample_stb == e_sample, "sample_stb R5", int'(sample_stb), int'(e_sample));
            chk(xfer_done == e_done, "xfer_done R6", int'(xfer_done), int'(e_done));
            chk(rel_done == e_rel, "rel_done R11", int'(rel_done), int'(e_rel));
            chk(ready == (m_ph == 0 || m_ph == 4), "ready R7 R12",
                int'(ready), int'(m_ph == 0 || m_ph == 4));
        end
    end

    task automatic set_clk(input bit pol, input bit pha, input int dv, input int su);
        clk_cfg = {8'h00, 8'(su), 8'(dv), 6'b0, pha, pol};
    endtask

    task automatic set_mode(input int csm, input int gap, input int inact);
        mode_cfg = {8'(inact), 8'(gap), 8'h00, 2'b00, 2'(csm), 4'b0000};
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic pulse_last();
        @(negedge clk) last_xfer = 1'b1;
        @(negedge clk) last_xfer = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 1000 && !(ready && cs_n); i++) @(negedge clk);
    endtask

    task automatic wait_hold();
        for (int i = 0; i < 1000 && !(ready && !cs_n); i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog R12 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        set_clk(1, 0, 1, 2);
        set_mode(2, 1, 2);
        repeat (3) @(negedge clk);
        // R1: state held by reset
        chk(cs_n == 1'b1, "R1 cs_n in reset", int'(cs_n), 1);
        chk(sck == 1'b1, "R1 sck idles at polarity", int'(sck), 1);
        chk(ready == 1'b1, "R1 ready in reset", int'(ready), 1);
        chk({shift_stb, sample_stb, xfer_done, rel_done} == 4'b0, "R1 pulses quiet",
            int'({shift_stb, sample_stb, xfer_done, rel_done}), 0);
        rst_n = 1'b1;

        // R8 mode 2, setup 2, divider 1
        pulse_start();
        wait_idle();
        chk(cs_n == 1'b1, "R8 released after transfer", int'(cs_n), 1);

        // R3 R4 R8: divider 0, zero delays, idle-high phase 1, mode 3
        set_clk(0, 1, 0, 0);
        set_mode(3, 0, 0);
        pulse_start();
        wait_idle();

        // R7 R9: mode 1 with gap, second start from hold, last during transfer
        set_clk(0, 0, 2, 1);
        set_mode(1, 2, 3);
        pulse_start();
        wait_hold();
        chk(cs_n == 1'b0, "R7 chip-select kept during gap", int'(cs_n), 0);
        pulse_start();
        repeat (3) @(negedge clk);
        pulse_last();
        wait_idle();
        chk(cs_n == 1'b1, "R9 released after last transfer", int'(cs_n), 1);

        // R9: release requested while waiting in hold
        set_clk(1, 1, 1, 0);
        pulse_start();
        wait_hold();
        pulse_last();
        chk(cs_n == 1'b1, "R9 release from hold", int'(cs_n), 1);
        wait_idle();

        // R12: starts during setup and during inactive time are dropped
        set_clk(1, 1, 1, 3);
        set_mode(2, 0, 4);
        pulse_start();
        pulse_start();
        for (int i = 0; i < 1000 && !xfer_done; i++) @(negedge clk);
        pulse_start();
        wait_idle();
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R12 no frame from ignored start", int'(cs_n), 1);

        // R10: mode 0 ignores last-transfer command
        set_clk(0, 0, 1, 1);
        set_mode(0, 1, 1);
        pulse_start();
        wait_hold();
        pulse_last();
        repeat (8) @(negedge clk);
        chk(cs_n == 1'b0, "R10 last ignored in mode 0", int'(cs_n), 0);
        pulse_start();
        wait_hold();
        chk(cs_n == 1'b0, "R10 still asserted after second transfer", int'(cs_n), 0);

        // R1: reset from an asserted frame
        @(negedge clk) rst_n = 1'b0;
        set_mode(2, 0, 0);
        repeat (2) @(negedge clk);
        chk(cs_n == 1'b1, "R1 reset releases chip-select", int'(cs_n), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ready == 1'b1, "R1 ready after reset", int'(ready), 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule